// File: doc/BRIEF.md
# Storage PHY Power-Up Sequencer

This block brings the analog front end of a storage-interface PHY out of power-down with no software involvement. On a power-up request it first forces the PHY power enable and the DLL enable low, so the pad-calibration logic inside the PHY starts from a clean state. After a settle interval it raises the power enable. After a calibration interval it checks the calibration-complete flag once. If the flag is set, it raises the DLL enable, waits a lock interval and checks the DLL-ready flag once.

A power-down request only forces both enables low and reports success. Each result is reported with a one-cycle completion pulse and a two-bit result code. Busy is high for the whole of a sequence. The three intervals are given in microseconds and converted to clock cycles from a clock-frequency parameter. The status flags are checked at one fixed cycle each and are not polled, so a flag that is late at its check point counts as a timeout.

Top module: `phy_pwr_seq`

## Requirements
- R1: After reset, both enables are low, busy and the completion pulse are low, and the result code is 0.
- R2: A power-up request seen while idle drives both enables low and raises busy at the same clock edge that samples the request.
- R3: The power enable rises exactly SETTLE_CYC = CLK_MHZ*SETTLE_US clock edges after the edge that accepted the power-up request, and the DLL enable stays low until then.
- R4: The calibration flag is sampled at the edge exactly CAL_CYC = CLK_MHZ*CAL_US edges after the power enable rose. If it is 0, both enables drop, busy falls, completion pulses and the result code becomes 1, all at that edge.
- R5: If calibration passes, the DLL enable rises at that sample edge. DLL-ready is sampled LOCK_CYC = CLK_MHZ*LOCK_US edges later. If it is 1, completion pulses, busy falls, the code becomes 0 and both enables stay high.
- R6: If DLL-ready is 0 at its sample edge, both enables drop, busy falls, completion pulses and the result code becomes 2.
- R7: A power-down request seen while idle drives both enables low and raises busy at the accepting edge. One edge later, busy falls, completion pulses and the code becomes 0.
- R8: Any power-up or power-down request that arrives while busy is high has no effect on the enables, busy, completion or result code.
- R9: When power-up and power-down are requested in the same idle cycle, only the power-down sequence runs.
- R10: Completion is high for exactly one cycle, at the edge where busy falls. The result code holds its value between completions.
- R11: The status flags have no effect outside their own sample edges. A flag that is set earlier but clear at its sample edge gives a timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_up_req | input | 1 | Start the power-up sequence (level sampled while idle) |
| pwr_dn_req | input | 1 | Start the power-down sequence (level sampled while idle) |
| cal_done_i | input | 1 | Pad calibration complete flag from the PHY |
| dll_rdy_i | input | 1 | DLL locked flag from the PHY |
| phy_pdb_o | output | 1 | PHY power enable (1 = powered) |
| phy_dll_en_o | output | 1 | PHY DLL enable |
| busy_o | output | 1 | A sequence is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 2 | Result code: 0 success, 1 calibration timeout, 2 DLL timeout |

## Verification
A status flag's sample edge can coincide with a new request: a stray power-up or power-down pulse is injected at the idle point, after settle, on the cycle before the calibration check, and on the cycle before completion. The expected enables, busy, pulse and code for every cycle of the run are computed from the three intervals and must be unchanged by the stray request. The two requests can also arrive together in one idle cycle. That case is provoked directly, and it is judged by seeing the one-edge power-down completion and then no rise of the power enable over a full settle interval. The flags are driven with the opposite value on every cycle except their sample edge, so any early or late sampling changes the result code.

// File: rtl/phy_pwr_seq_pkg.sv
`timescale 1ns/1ps
package phy_pwr_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SETTLE = 3'd1,
    ST_CAL    = 3'd2,
    ST_LOCK   = 3'd3,
    ST_DOWN   = 3'd4
  } seq_state_e;

  localparam logic [1:0] RES_OK      = 2'd0;
  localparam logic [1:0] RES_CAL_TMO = 2'd1;
  localparam logic [1:0] RES_DLL_TMO = 2'd2;

  function automatic int unsigned us_to_cyc(input int unsigned mhz, input int unsigned us);
    int unsigned c;
    c = mhz * us;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/phy_pwr_req.sv
`timescale 1ns/1ps
module phy_pwr_req (
  input  logic clk,
  input  logic rst,
  input  logic up_i,
  input  logic dn_i,
  input  logic busy_i,
  output logic start_up_o,
  output logic start_dn_o
);

  // Power-down wins over power-up; nothing starts while busy.
  always_comb begin
    start_dn_o = dn_i && !busy_i;
    start_up_o = up_i && !dn_i && !busy_i;
  end

  p_single_start_r9: assert property (@(posedge clk) disable iff (rst)
    !(start_up_o && start_dn_o));

endmodule

// File: rtl/phy_pwr_timer.sv
`timescale 1ns/1ps
module phy_pwr_timer #(
  parameter int unsigned CW   = 8,
  parameter int unsigned MAXV = 100
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          expired_o
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired_o = (cnt_q == '0);

  p_cnt_bounded_r3: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(MAXV));

  p_expire_after_load_r3: assert property (@(posedge clk) disable iff (rst)
    (load_i && load_val_i != '0) |=> !expired_o);

endmodule

// File: rtl/phy_pwr_fsm.sv
`timescale 1ns/1ps
module phy_pwr_fsm
  import phy_pwr_seq_pkg::*;
#(
  parameter int unsigned CW         = 8,
  parameter int unsigned SETTLE_CYC = 3,
  parameter int unsigned CAL_CYC    = 5,
  parameter int unsigned LOCK_CYC   = 30
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_up_i,
  input  logic          start_dn_i,
  input  logic          cal_done_i,
  input  logic          dll_rdy_i,
  input  logic          tmr_expired_i,
  output logic          tmr_load_o,
  output logic [CW-1:0] tmr_val_o,
  output logic          pdb_o,
  output logic          dll_en_o,
  output logic          busy_o,
  output logic          done_o,
  output logic [1:0]    result_o
);

  localparam logic [CW-1:0] SETTLE_LD = CW'(SETTLE_CYC - 1);
  localparam logic [CW-1:0] CAL_LD    = CW'(CAL_CYC - 1);
  localparam logic [CW-1:0] LOCK_LD   = CW'(LOCK_CYC - 1);

  seq_state_e state_q;

  // Timer reload at every phase entry.
  always_comb begin
    tmr_load_o = 1'b0;
    tmr_val_o  = '0;
    unique case (state_q)
      ST_IDLE: if (start_up_i && !start_dn_i) begin
        tmr_load_o = 1'b1;
        tmr_val_o  = SETTLE_LD;
      end
      ST_SETTLE: if (tmr_expired_i) begin
        tmr_load_o = 1'b1;
        tmr_val_o  = CAL_LD;
      end
      ST_CAL: if (tmr_expired_i && cal_done_i) begin
        tmr_load_o = 1'b1;
        tmr_val_o  = LOCK_LD;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      pdb_o    <= 1'b0;
      dll_en_o <= 1'b0;
      busy_o   <= 1'b0;
      done_o   <= 1'b0;
      result_o <= RES_OK;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_dn_i) begin
            pdb_o    <= 1'b0;
            dll_en_o <= 1'b0;
            busy_o   <= 1'b1;
            state_q  <= ST_DOWN;
          end else if (start_up_i) begin
            pdb_o    <= 1'b0;
            dll_en_o <= 1'b0;
            busy_o   <= 1'b1;
            state_q  <= ST_SETTLE;
          end
        end
        ST_SETTLE: begin
          if (tmr_expired_i) begin
            pdb_o   <= 1'b1;
            state_q <= ST_CAL;
          end
        end
        ST_CAL: begin
          if (tmr_expired_i) begin
            if (cal_done_i) begin
              dll_en_o <= 1'b1;
              state_q  <= ST_LOCK;
            end else begin
              pdb_o    <= 1'b0;
              dll_en_o <= 1'b0;
              busy_o   <= 1'b0;
              done_o   <= 1'b1;
              result_o <= RES_CAL_TMO;
              state_q  <= ST_IDLE;
            end
          end
        end
        ST_LOCK: begin
          if (tmr_expired_i) begin
            busy_o  <= 1'b0;
            done_o  <= 1'b1;
            state_q <= ST_IDLE;
            if (dll_rdy_i) begin
              result_o <= RES_OK;
            end else begin
              pdb_o    <= 1'b0;
              dll_en_o <= 1'b0;
              result_o <= RES_DLL_TMO;
            end
          end
        end
        ST_DOWN: begin
          busy_o   <= 1'b0;
          done_o   <= 1'b1;
          result_o <= RES_OK;
          state_q  <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  p_dll_needs_pdb_r5: assert property (@(posedge clk) disable iff (rst)
    dll_en_o |-> pdb_o);

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  p_done_ends_busy_r10: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!busy_o && $past(busy_o)));

  p_result_legal_r4: assert property (@(posedge clk) disable iff (rst)
    result_o != 2'd3);

  p_fail_drops_r6: assert property (@(posedge clk) disable iff (rst)
    (done_o && result_o != RES_OK) |-> (!pdb_o && !dll_en_o));

  p_start_clears_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> (!pdb_o && !dll_en_o));

  p_pdb_rise_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(pdb_o) |-> (busy_o && !dll_en_o));

  p_result_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> $stable(result_o));

endmodule

// File: rtl/phy_pwr_seq.sv
`timescale 1ns/1ps
module phy_pwr_seq
  import phy_pwr_seq_pkg::*;
#(
  parameter int unsigned CLK_MHZ   = 100,
  parameter int unsigned SETTLE_US = 3,
  parameter int unsigned CAL_US    = 5,
  parameter int unsigned LOCK_US   = 30
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pwr_up_req,
  input  logic       pwr_dn_req,
  input  logic       cal_done_i,
  input  logic       dll_rdy_i,
  output logic       phy_pdb_o,
  output logic       phy_dll_en_o,
  output logic       busy_o,
  output logic       done_o,
  output logic [1:0] result_o
);

  localparam int unsigned SETTLE_CYC = us_to_cyc(CLK_MHZ, SETTLE_US);
  localparam int unsigned CAL_CYC    = us_to_cyc(CLK_MHZ, CAL_US);
  localparam int unsigned LOCK_CYC   = us_to_cyc(CLK_MHZ, LOCK_US);
  localparam int unsigned MAX_CYC    = max3(SETTLE_CYC, CAL_CYC, LOCK_CYC);
  localparam int unsigned CW         = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);

  logic          start_up;
  logic          start_dn;
  logic          tmr_load;
  logic [CW-1:0] tmr_val;
  logic          tmr_expired;

  phy_pwr_req u_req (
    .clk        (clk),
    .rst        (rst),
    .up_i       (pwr_up_req),
    .dn_i       (pwr_dn_req),
    .busy_i     (busy_o),
    .start_up_o (start_up),
    .start_dn_o (start_dn)
  );

  phy_pwr_timer #(
    .CW   (CW),
    .MAXV (MAX_CYC - 1)
  ) u_tmr (
    .clk        (clk),
    .rst        (rst),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .expired_o  (tmr_expired)
  );

  phy_pwr_fsm #(
    .CW         (CW),
    .SETTLE_CYC (SETTLE_CYC),
    .CAL_CYC    (CAL_CYC),
    .LOCK_CYC   (LOCK_CYC)
  ) u_fsm (
    .clk           (clk),
    .rst           (rst),
    .start_up_i    (start_up),
    .start_dn_i    (start_dn),
    .cal_done_i    (cal_done_i),
    .dll_rdy_i     (dll_rdy_i),
    .tmr_expired_i (tmr_expired),
    .tmr_load_o    (tmr_load),
    .tmr_val_o     (tmr_val),
    .pdb_o         (phy_pdb_o),
    .dll_en_o      (phy_dll_en_o),
    .busy_o        (busy_o),
    .done_o        (done_o),
    .result_o      (result_o)
  );

endmodule

// File: tb/phy_pwr_seq_tb_top.sv
`timescale 1ns/1ps
module phy_pwr_seq_tb_top;

  localparam int MHZ = 1;
  localparam int S   = MHZ * 3;
  localparam int C   = MHZ * 5;
  localparam int L   = MHZ * 30;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pwr_up_req = 1'b0;
  logic       pwr_dn_req = 1'b0;
  logic       cal_done_i = 1'b0;
  logic       dll_rdy_i  = 1'b0;
  logic       phy_pdb_o, phy_dll_en_o, busy_o, done_o;
  logic [1:0] result_o;

  int vectors = 0;
  int fails   = 0;
  int cycles  = 0;
  int last_res = 0;

  always #5 clk = ~clk;

  phy_pwr_seq #(
    .CLK_MHZ (MHZ), .SETTLE_US (3), .CAL_US (5), .LOCK_US (30)
  ) dut_i (
    .clk (clk), .rst (rst),
    .pwr_up_req (pwr_up_req), .pwr_dn_req (pwr_dn_req),
    .cal_done_i (cal_done_i), .dll_rdy_i (dll_rdy_i),
    .phy_pdb_o (phy_pdb_o), .phy_dll_en_o (phy_dll_en_o),
    .busy_o (busy_o), .done_o (done_o), .result_o (result_o)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 100000) begin
      fails = fails + 1;
      $display("FAIL watchdog: got %0d cycles expected under 100000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic chk(input string tag, input string sig, input int act, input int exp);
    vectors = vectors + 1;
    if (act != exp) begin
      fails = fails + 1;
      $display("FAIL %s %s: got %0d expected %0d at %0t", tag, sig, act, exp, $time);
    end
  endtask

  // Power-up run. Flags carry the opposite value except at their sample edge (R11).
  // A stray request (up or down) is injected for one cycle at step inj_k (R8).
  task automatic run_up(input bit cal_ok, input bit dll_ok, input int inj_k, input bit inj_dn);
    int t;
    int code;
    string rt;
    string xt;
    t    = cal_ok ? S + C + L : S + C;
    code = !cal_ok ? 1 : (dll_ok ? 0 : 2);
    rt   = !cal_ok ? "R4 R11" : (dll_ok ? "R5 R11" : "R6 R11");
    pwr_up_req = 1'b1;
    cal_done_i = (S + C == 0) ? cal_ok : !cal_ok;
    dll_rdy_i  = !dll_ok;
    @(negedge clk);
    for (int k = 0; k <= t + 2; k++) begin
      int e_pdb, e_dll, e_busy, e_done, e_res;
      xt = (inj_k >= 0 && k > inj_k) ? " R8" : "";
      e_pdb  = (k >= S) && (k < t || (cal_ok && dll_ok));
      e_dll  = cal_ok && (k >= S + C) && (k < t || dll_ok);
      e_busy = (k < t);
      e_done = (k == t);
      e_res  = (k >= t) ? code : last_res;
      if (k == 0) begin
        chk({"R2", xt}, "pdb", phy_pdb_o, e_pdb);
        chk({"R2", xt}, "dll_en", phy_dll_en_o, e_dll);
      end else begin
        chk({(k >= t) ? rt : "R3", xt}, "pdb", phy_pdb_o, e_pdb);
        chk({(k >= t) ? rt : "R5", xt}, "dll_en", phy_dll_en_o, e_dll);
      end
      chk({"R10", xt}, "busy", busy_o, e_busy);
      chk({"R10", xt}, "done", done_o, e_done);
      chk({rt, xt}, "result", result_o, e_res);
      pwr_up_req = (k == inj_k) && !inj_dn;
      pwr_dn_req = (k == inj_k) && inj_dn;
      cal_done_i = (k + 1 == S + C) ? cal_ok : !cal_ok;
      dll_rdy_i  = (k + 1 == S + C + L) ? dll_ok : !dll_ok;
      @(negedge clk);
    end
    pwr_up_req = 1'b0;
    pwr_dn_req = 1'b0;
    last_res = code;
  endtask

  // Power-down run; with both set, power-up is requested in the same cycle (R9).
  task automatic run_dn(input bit both);
    string tg;
    tg = both ? "R9" : "R7";
    pwr_dn_req = 1'b1;
    pwr_up_req = both;
    @(negedge clk);
    pwr_dn_req = 1'b0;
    pwr_up_req = 1'b0;
    chk(tg, "pdb", phy_pdb_o, 0);
    chk(tg, "dll_en", phy_dll_en_o, 0);
    chk(tg, "busy", busy_o, 1);
    chk(tg, "done", done_o, 0);
    @(negedge clk);
    chk(tg, "busy", busy_o, 0);
    chk(tg, "done", done_o, 1);
    chk(tg, "result", result_o, 0);
    for (int k = 2; k < S + 4; k++) begin
      @(negedge clk);
      chk(tg, "pdb", phy_pdb_o, 0);
      chk(tg, "busy", busy_o, 0);
      chk("R10", "done", done_o, 0);
    end
    last_res = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1", "pdb", phy_pdb_o, 0);
    chk("R1", "dll_en", phy_dll_en_o, 0);
    chk("R1", "busy", busy_o, 0);
    chk("R1", "done", done_o, 0);
    chk("R1", "result", result_o, 0);
    @(negedge clk);
    run_dn(1'b0);
    for (int cal = 0; cal < 2; cal++) begin
      for (int dll = 0; dll < 2; dll++) begin
        int t;
        t = cal ? S + C + L : S + C;
        for (int j = 0; j < 5; j++) begin
          int inj;
          case (j)
            0: inj = -1;
            1: inj = 0;
            2: inj = S - 1;
            3: inj = S + C - 2;
            default: inj = t - 2;
          endcase
          run_up(cal[0], dll[0], inj, j[0]);
        end
      end
    end
    // Power-down after a successful power-up drops the enables (R7)
    run_up(1'b1, 1'b1, -1, 1'b0);
    run_dn(1'b0);
    // Simultaneous requests after success: power-down wins (R9)
    run_up(1'b1, 1'b1, -1, 1'b0);
    run_dn(1'b1);
    // Back-to-back power-up right after a failure
    run_up(1'b0, 1'b1, -1, 1'b0);
    run_up(1'b1, 1'b0, -1, 1'b0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule